// File: doc/BRIEF.md
# Serial Configuration Slave with Strap Override

This block is a two-wire serial slave that gives a host controller read and write access to a small file of 8-bit configuration registers. SCL and SDA are oversampled by the system clock, which must run at least eight times faster than SCL. The slave finds START, repeated START and STOP conditions. It answers to one of four 7-bit bus addresses, which a 2-bit select input picks. Bytes are shifted in on SCL rising edges. SDA is changed only while SCL is low, and the slave drives SDA low only through an open-drain enable, so it never drives the line high.

A write transfer carries a register pointer byte first and then data bytes. The pointer advances after every data byte. A read transfer, usually reached through a repeated START after the pointer has been set, returns bytes from the pointer onward for as long as the host acknowledges. Register 0 selects where the configuration outputs come from. While it holds anything other than 0x01, the outputs mirror the strap inputs. Once 0x01 is stored there, the outputs carry registers 1 and up. For a programmable number of clock cycles after reset, the slave ignores the bus completely.

Controller states: `ST_IDLE` (bus free or not addressed), `ST_ADDR` (address byte shifting), `ST_ADDR_ACK` (ninth clock of a matched address), `ST_PTR` / `ST_PTR_ACK` (pointer byte and its acknowledge), `ST_WDATA` / `ST_WDATA_ACK` (write data and its acknowledge), `ST_RDATA` (slave sends a byte), `ST_RACK` (host acknowledge of a read byte), `ST_WAIT` (ignoring the bus until the next START or STOP). Transitions: any state goes to `ST_IDLE` on STOP. Any state goes to `ST_ADDR` on START, or to `ST_IDLE` if the START falls inside the lockout. `ST_ADDR` goes to `ST_ADDR_ACK` on a match and to `ST_WAIT` on a mismatch. `ST_ADDR_ACK` goes to `ST_RDATA` for a read and to `ST_PTR` for a write. `ST_PTR` goes to `ST_PTR_ACK`, then to `ST_WDATA`. `ST_WDATA` and `ST_WDATA_ACK` alternate. `ST_RDATA` goes to `ST_RACK`. From `ST_RACK` the host's ACK leads back to `ST_RDATA` and its NACK leads to `ST_WAIT`.

Top module: `cfg_i2c_slave`

## Requirements
- R1: After reset, register 0 holds 0x00, every other register holds 0x00, and `cfg_o` equals `strap_i`.
- R2: The bus address is taken from `addr_sel_i` on the first clock after reset release: 00 gives 0x6A, 01 gives 0x6B, 10 gives 0x6E, 11 gives 0x69. Later changes of `addr_sel_i` have no effect until the next reset.
- R3: The first byte after a START is the 7-bit address followed by the R/W bit (1 = read) in bit 0. When the address matches, the slave drives SDA low during the ninth SCL clock.
- R4: When the address does not match, the slave leaves SDA released in the ninth clock and ignores every byte until the next START or STOP. Register contents are unchanged.
- R5: In a write transfer, the byte after the address sets the register pointer. Each later byte is stored at the pointer, and the pointer then advances by one. The slave acknowledges the pointer byte and every data byte.
- R6: In a read transfer, the slave sends the register at the pointer MSB first and advances the pointer after each byte. It sends another byte while the host acknowledges. After a host NACK it releases SDA until the next START or STOP. A pointer beyond the last register reads 0x00.
- R7: While register 0 equals exactly 0x01, `cfg_o` carries the registers, with register k in bits [8k-1:8k-8]. With any other value in register 0, `cfg_o` equals `strap_i`.
- R8: For `LOCKOUT_CYCLES` clock cycles after reset, the slave ignores every START and never drives SDA.
- R9: `sda_oe_o` = 1 pulls SDA low and 0 releases it. It only changes while the synchronised SCL is low.
- R10: A STOP (SDA rising while SCL is high) returns the slave to idle. A repeated START at any point restarts the address phase, so a write after a repeated START uses the new pointer byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel_i | input | 2 | Bus address select, captured after reset |
| scl_i | input | 1 | Serial clock line as seen on the pad |
| sda_i | input | 1 | Serial data line as seen on the pad |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| strap_i | input | (NUM_REGS-1)*8 | Strap values used while the override is off |
| cfg_o | output | (NUM_REGS-1)*8 | Configuration outputs |

## Verification
The main function is tried with write bursts of several bytes, pointer-set-then-read sequences using repeated START, and reads that run past the last register. These patterns separate pointer advance from fresh addressing and show the zero fill beyond the file. Address bytes are sent with all four select codes, with a neighbouring wrong address, and while the lockout runs. This separates a match from a silent NACK and from the lockout. A repeated START in the middle of a write burst shows that the pointer is re-taken from the new transfer. The override is exercised with 0x01 and with another non-zero value, while the strap inputs are changed at the same time.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_WAIT
    } slv_state_e;

    // value in register 0 that hands the outputs to the register file
    localparam logic [7:0] OVERRIDE_KEY = 8'h01;

    function automatic logic [6:0] sel_to_addr(input logic [1:0] sel);
        logic [6:0] a;
        case (sel)
            2'b00:   a = 7'h6A;
            2'b01:   a = 7'h6B;
            2'b10:   a = 7'h6E;
            default: a = 7'h69;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    // idle bus is high on both lines
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_o      = scl_pipe[STAGES-1];
    assign sda_o      = sda_pipe[STAGES-1];
    assign scl_rise_o = scl_o & ~scl_d;
    assign scl_fall_o = ~scl_o & scl_d;
    // data edges with the clock high on both samples
    assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
    assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;

endmodule

// File: rtl/cfg_lockout.sv
module cfg_lockout #(
    parameter int CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    output logic busy_o
);

    localparam int CNT_W = $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign busy_o = (cnt != LAST);

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
    import cfg_i2c_pkg::*;
#(
    parameter int NUM_REGS = 4,
    localparam int CFG_W = (NUM_REGS - 1) * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [7:0]       wr_addr_i,
    input  logic [7:0]       wr_data_i,
    input  logic [7:0]       rd_addr_i,
    output logic [7:0]       rd_data_o,
    input  logic [CFG_W-1:0] strap_i,
    output logic [CFG_W-1:0] cfg_o,
    output logic             override_o
);

    logic [7:0]       regs [NUM_REGS];
    logic [CFG_W-1:0] reg_flat;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= 8'h00;
            end else if (wr_en_i && (wr_addr_i == 8'(g))) begin
                regs[g] <= wr_data_i;
            end
        end
    end

    for (genvar g = 1; g < NUM_REGS; g++) begin : g_flat
        assign reg_flat[(g-1)*8 +: 8] = regs[g];
    end

    // pointer beyond the file returns zero
    always_comb begin
        rd_data_o = 8'h00;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr_i == 8'(i)) begin
                rd_data_o = regs[i];
            end
        end
    end

    assign override_o = (regs[0] == OVERRIDE_KEY);
    assign cfg_o      = override_o ? reg_flat : strap_i;

endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave
    import cfg_i2c_pkg::*;
#(
    parameter int NUM_REGS       = 4,
    parameter int LOCKOUT_CYCLES = 500000,
    parameter int SYNC_STAGES    = 2,
    localparam int CFG_W = (NUM_REGS - 1) * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       addr_sel_i,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe_o,
    input  logic [CFG_W-1:0] strap_i,
    output logic [CFG_W-1:0] cfg_o
);

    slv_state_e state, state_nx;

    logic       scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic       lock_busy;
    logic [1:0] sel_q;
    logic       sel_taken;
    logic [6:0] my_addr;
    logic [3:0] bit_cnt;
    logic [7:0] shift;
    logic [7:0] tx;
    logic [7:0] ptr;
    logic       rw;
    logic       oe;
    logic       mst_nack;
    logic       byte_done;
    logic       addr_hit;
    logic       wr_en;
    logic [7:0] rd_data;
    logic       override;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (bus_start),
        .stop_o     (bus_stop)
    );

    cfg_lockout #(.CYCLES(LOCKOUT_CYCLES)) lock_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .busy_o (lock_busy)
    );

    cfg_regfile #(.NUM_REGS(NUM_REGS)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .wr_addr_i  (ptr),
        .wr_data_i  (shift),
        .rd_addr_i  (ptr),
        .rd_data_o  (rd_data),
        .strap_i    (strap_i),
        .cfg_o      (cfg_o),
        .override_o (override)
    );

    // address select taken once, on the first clock after reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q     <= 2'b00;
            sel_taken <= 1'b0;
        end else if (!sel_taken) begin
            sel_q     <= addr_sel_i;
            sel_taken <= 1'b1;
        end
    end

    assign my_addr   = sel_to_addr(sel_q);
    assign byte_done = (bit_cnt == 4'd8);
    assign addr_hit  = (shift[7:1] == my_addr);
    assign wr_en     = scl_fall && byte_done && (state == ST_WDATA)
                       && !bus_start && !bus_stop;

    // next-state logic
    always_comb begin
        state_nx = state;
        if (bus_stop) begin
            state_nx = ST_IDLE;
        end else if (bus_start) begin
            state_nx = lock_busy ? ST_IDLE : ST_ADDR;
        end else if (scl_fall) begin
            unique case (state)
                ST_IDLE:      state_nx = ST_IDLE;
                ST_ADDR:      if (byte_done) state_nx = addr_hit ? ST_ADDR_ACK : ST_WAIT;
                ST_ADDR_ACK:  state_nx = rw ? ST_RDATA : ST_PTR;
                ST_PTR:       if (byte_done) state_nx = ST_PTR_ACK;
                ST_PTR_ACK:   state_nx = ST_WDATA;
                ST_WDATA:     if (byte_done) state_nx = ST_WDATA_ACK;
                ST_WDATA_ACK: state_nx = ST_WDATA;
                ST_RDATA:     if (byte_done) state_nx = ST_RACK;
                ST_RACK:      state_nx = mst_nack ? ST_WAIT : ST_RDATA;
                ST_WAIT:      state_nx = ST_WAIT;
                default:      state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // datapath and line driver
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= 4'd0;
            shift    <= 8'h00;
            tx       <= 8'h00;
            ptr      <= 8'h00;
            rw       <= 1'b0;
            oe       <= 1'b0;
            mst_nack <= 1'b0;
        end else if (bus_start || bus_stop) begin
            bit_cnt <= 4'd0;
            oe      <= 1'b0;
        end else begin
            if (scl_rise) begin
                if (state inside {ST_ADDR, ST_PTR, ST_WDATA, ST_RDATA}) begin
                    bit_cnt <= bit_cnt + 4'd1;
                end
                if (state inside {ST_ADDR, ST_PTR, ST_WDATA}) begin
                    shift <= {shift[6:0], sda_s};
                end
                if (state == ST_RACK) begin
                    mst_nack <= sda_s;
                end
            end
            if (scl_fall) begin
                case (state)
                    ST_ADDR: begin
                        if (byte_done) begin
                            bit_cnt <= 4'd0;
                            oe      <= addr_hit;
                            rw      <= shift[0];
                        end
                    end
                    ST_ADDR_ACK, ST_RACK: begin
                        if ((state == ST_ADDR_ACK && rw) ||
                            (state == ST_RACK && !mst_nack)) begin
                            tx      <= rd_data;
                            oe      <= ~rd_data[7];
                            bit_cnt <= 4'd0;
                        end else begin
                            oe <= 1'b0;
                        end
                    end
                    ST_PTR: begin
                        if (byte_done) begin
                            ptr     <= shift;
                            oe      <= 1'b1;
                            bit_cnt <= 4'd0;
                        end
                    end
                    ST_WDATA: begin
                        if (byte_done) begin
                            ptr     <= ptr + 8'd1;
                            oe      <= 1'b1;
                            bit_cnt <= 4'd0;
                        end
                    end
                    ST_RDATA: begin
                        if (byte_done) begin
                            oe  <= 1'b0;
                            ptr <= ptr + 8'd1;
                        end else begin
                            tx <= {tx[6:0], 1'b0};
                            oe <= ~tx[6];
                        end
                    end
                    default: oe <= 1'b0;
                endcase
            end
        end
    end

    assign sda_oe_o = oe;

endmodule

// File: rtl/cfg_i2c_slave_chk.sv
module cfg_i2c_slave_chk
    import cfg_i2c_pkg::*;
#(
    parameter int CFG_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_s,
    input logic             lock_busy,
    input slv_state_e       state,
    input logic             sda_oe_o,
    input logic             override,
    input logic [CFG_W-1:0] strap_i,
    input logic [CFG_W-1:0] cfg_o
);

    // R8
    lockout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_busy |-> !sda_oe_o);

    // R9
    sda_change_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_s);

    // R7
    strap_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !override |-> (cfg_o == strap_i));

    // R4
    ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> !sda_oe_o);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe_o);

endmodule

bind cfg_i2c_slave cfg_i2c_slave_chk #(.CFG_W(CFG_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .lock_busy (lock_busy),
    .state     (state),
    .sda_oe_o  (sda_oe_o),
    .override  (override),
    .strap_i   (strap_i),
    .cfg_o     (cfg_o)
);

// File: tb/cfg_i2c_slave_tb_top.sv
module cfg_i2c_slave_tb_top;

    localparam int NREG = 4;
    localparam int CW   = (NREG - 1) * 8;
    localparam int LOCK = 300;
    localparam int Q    = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    sel = 2'b00;
    logic          scl_m = 1'b1;
    logic          sda_m = 1'b1;
    logic          sda_oe;
    logic [CW-1:0] strap = 24'hA55A3C;
    logic [CW-1:0] cfg;
    logic          sda_bus;
    logic          done = 1'b0;

    always #10 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    cfg_i2c_slave #(
        .NUM_REGS       (NREG),
        .LOCKOUT_CYCLES (LOCK),
        .SYNC_STAGES    (2)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_sel_i (sel),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .sda_oe_o   (sda_oe),
        .strap_i    (strap),
        .cfg_o      (cfg)
    );

    typedef struct {
        string       req;
        logic [31:0] exp;
    } exp_t;

    exp_t        sb_q[$];
    logic [31:0] obs_val;
    event        obs_ev;
    int          n_cmp = 0;
    int          n_bad = 0;

    // monitor: pops the oldest expectation for each observed result
    initial begin
        forever begin
            @(obs_ev);
            if (sb_q.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL unmatched result actual %0h expected none", obs_val);
            end else begin
                exp_t it;
                it = sb_q.pop_front();
                n_cmp++;
                if (obs_val !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s actual %0h expected %0h", it.req, obs_val, it.exp);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] e);
        sb_q.push_back('{req: r, exp: e});
        obs_val = act;
        ->obs_ev;
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2 * Q);
    endtask

    task automatic wbit(input logic b);
        sda_m = b; tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic rbit(output logic b);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        b = sda_bus; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic wbyte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) wbit(d[i]);
        rbit(b);
        ack = ~b;
    endtask

    task automatic rbyte(output logic [7:0] d, input logic last);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            rbit(b);
            d[i] = b;
        end
        wbit(last);
    endtask

    task automatic do_reset(input logic [1:0] s);
        rst_n = 1'b0;
        sel = s;
        tick(3);
        rst_n = 1'b1;
        tick(LOCK + 20);
    endtask

    // single register read through a repeated START
    task automatic rd_reg(input logic [6:0] a, input logic [7:0] p, output logic [7:0] d);
        logic ack;
        bus_start();
        wbyte({a, 1'b0}, ack);
        wbyte(p, ack);
        bus_start();
        wbyte({a, 1'b1}, ack);
        rbyte(d, 1'b1);
        bus_stop();
    endtask

    task automatic wr_reg(input logic [6:0] a, input logic [7:0] p, input logic [7:0] d);
        logic ack;
        bus_start();
        wbyte({a, 1'b0}, ack);
        wbyte(p, ack);
        wbyte(d, ack);
        bus_stop();
    endtask

    task automatic probe(input logic [6:0] a, output logic ack);
        bus_start();
        wbyte({a, 1'b0}, ack);
        bus_stop();
    endtask

    initial begin
        logic       ack;
        logic [7:0] d;
        logic [6:0] amap [4];
        amap[0] = 7'h6A; amap[1] = 7'h6B; amap[2] = 7'h6E; amap[3] = 7'h69;

        // reset state, checked inside the lockout window
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        chk("R1 cfg follows strap after reset", 32'(cfg), 32'(strap));
        chk("R9 line released after reset", 32'(sda_oe), 32'd0);

        // lockout: address byte is ignored
        bus_start();
        wbyte({7'h6A, 1'b0}, ack);
        chk("R8 no ack during lockout", 32'(ack), 32'd0);
        bus_stop();
        tick(LOCK);

        rd_reg(7'h6A, 8'h00, d);
        chk("R1 register 0 reads 0x00", 32'(d), 32'h00);
        rd_reg(7'h6A, 8'h02, d);
        chk("R1 register 2 reads 0x00", 32'(d), 32'h00);

        // burst write
        bus_start();
        wbyte({7'h6A, 1'b0}, ack);
        chk("R3 address ack", 32'(ack), 32'd1);
        wbyte(8'h01, ack);
        chk("R5 pointer ack", 32'(ack), 32'd1);
        wbyte(8'h11, ack);
        chk("R5 data ack 1", 32'(ack), 32'd1);
        wbyte(8'h22, ack);
        chk("R5 data ack 2", 32'(ack), 32'd1);
        wbyte(8'h33, ack);
        chk("R5 data ack 3", 32'(ack), 32'd1);
        bus_stop();
        chk("R7 strap kept with override off", 32'(cfg), 32'(strap));

        // burst read past the end of the file
        bus_start();
        wbyte({7'h6A, 1'b0}, ack);
        wbyte(8'h01, ack);
        bus_start();
        wbyte({7'h6A, 1'b1}, ack);
        chk("R3 read address ack", 32'(ack), 32'd1);
        rbyte(d, 1'b0);
        chk("R6 read byte 1", 32'(d), 32'h11);
        rbyte(d, 1'b0);
        chk("R6 read byte 2", 32'(d), 32'h22);
        rbyte(d, 1'b0);
        chk("R6 read byte 3", 32'(d), 32'h33);
        rbyte(d, 1'b1);
        chk("R6 beyond file reads zero", 32'(d), 32'h00);
        tick(Q);
        chk("R6 released after host nack", 32'(sda_oe), 32'd0);
        bus_stop();

        // mismatched address, following bytes ignored
        bus_start();
        wbyte({7'h6B, 1'b0}, ack);
        chk("R4 wrong address nack", 32'(ack), 32'd0);
        wbyte(8'h01, ack);
        chk("R4 pointer byte ignored", 32'(ack), 32'd0);
        wbyte(8'h77, ack);
        bus_stop();
        rd_reg(7'h6A, 8'h01, d);
        chk("R4 register unchanged", 32'(d), 32'h11);

        // override on
        wr_reg(7'h6A, 8'h00, 8'h01);
        chk("R7 registers drive cfg", 32'(cfg), 32'h332211);
        strap = 24'h0F0F0F;
        tick(2);
        chk("R7 strap change ignored", 32'(cfg), 32'h332211);
        wr_reg(7'h6A, 8'h00, 8'h02);
        chk("R7 other value returns strap", 32'(cfg), 32'(strap));
        rd_reg(7'h6A, 8'h00, d);
        chk("R7 register 0 readback", 32'(d), 32'h02);

        // repeated START in the middle of a write burst
        bus_start();
        wbyte({7'h6A, 1'b0}, ack);
        wbyte(8'h02, ack);
        wbyte(8'h44, ack);
        bus_start();
        wbyte({7'h6A, 1'b0}, ack);
        chk("R10 ack after repeated start", 32'(ack), 32'd1);
        wbyte(8'h03, ack);
        wbyte(8'h55, ack);
        bus_stop();
        rd_reg(7'h6A, 8'h02, d);
        chk("R10 first part stored", 32'(d), 32'h44);
        rd_reg(7'h6A, 8'h03, d);
        chk("R10 new pointer used", 32'(d), 32'h55);

        // every address select code
        for (int s = 0; s < 4; s++) begin
            do_reset(2'(s));
            probe(amap[s], ack);
            chk($sformatf("R2 select %0d own address", s), 32'(ack), 32'd1);
            probe(amap[(s + 1) % 4], ack);
            chk($sformatf("R2 select %0d other address", s), 32'(ack), 32'd0);
            sel = 2'((s + 1) % 4);
            tick(4);
            probe(amap[s], ack);
            chk($sformatf("R2 select %0d late change ignored", s), 32'(ack), 32'd1);
        end

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        tick(150000);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule